// File: doc/BRIEF.md
# Heartbeat-Period Peak Scanner

This block looks for beat peaks inside one stretch of filtered ECG samples that sit in a sample memory. The stretch starts at a given address and is as long as a heartbeat period that was estimated earlier. The scanner reads the stretch twice through a synchronous memory read port. The first read-through finds the largest sample. The detection level is then set to three fifths of that value. The second read-through reports each local maximum that rises above that level.

Every reported peak is one beat of the result stream. It carries the peak's offset inside the window, its amplitude, and the distance in samples back to the previous peak of the same window. A running peak count stays on the outputs after the scan ends. A single-cycle done pulse marks the end of the scan.

The controller is one enumerated state machine with these states:
- `S_IDLE`: waits for `start`. It goes to `S_FINISH` when the length is zero, and to `S_PASS1` otherwise.
- `S_PASS1`: issues one read per cycle. After the last offset it goes to `S_TAIL1`.
- `S_TAIL1`: takes in the last sample of the first pass, then goes to `S_THRESH`.
- `S_THRESH`: latches the threshold, then goes to `S_PASS2`.
- `S_PASS2`: re-reads the window. After the last offset it goes to `S_TAIL2`.
- `S_TAIL2`: takes in the last sample, then goes to `S_FINISH`.
- `S_FINISH`: raises done, then returns to `S_IDLE`.

A `start` that arrives outside `S_IDLE` is not acted on.

Top module: `beat_peak_scan`

## Requirements
- R1: A start with a window length of zero raises `done` in the cycle after `start` is sampled, with `pk_count` equal to 0, and no peak is reported.
- R2: The threshold is floor(max×3/5), where max is the largest unsigned 16-bit sample in the window. A reported peak's amplitude is strictly above the threshold, so a sample equal to the threshold is never reported.
- R3: An interior sample s[i] is a peak when s[i] > s[i-1] and s[i] >= s[i+1]. On a flat top only the first sample of the run is reported.
- R4: The sample at offset 0 and the sample at offset length-1 are never reported, whatever their values.
- R5: `pk_index` is the offset of the peak from `win_base`, and `pk_amp` is the sample value stored at address `win_base + pk_index`.
- R6: `pk_gap` is 0 for the first peak of a window. For each later peak it is the offset difference from the peak reported just before it.
- R7: `done` is high for exactly one cycle. No peak is reported after it. `pk_count` equals the number of peaks reported and keeps its value until the next accepted start.
- R8: The threshold comes from the whole window before any peak is reported. A local maximum that lies before a larger sample and is not above 3/5 of that larger sample is not reported.
- R9: After reset, `done` and `pk_valid` are low and `pk_count` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Starts a scan; taken only when idle |
| win_base | input | ADDR_W | First sample address of the window |
| win_len | input | LEN_W | Window length in samples |
| mem_rd | output | 1 | Read request to the sample memory |
| mem_addr | output | ADDR_W | Read address |
| mem_rdata | input | SAMPLE_W | Read data, valid one cycle after the request |
| pk_valid | output | 1 | A peak is on the result outputs this cycle |
| pk_index | output | LEN_W | Peak offset inside the window |
| pk_amp | output | SAMPLE_W | Peak amplitude |
| pk_gap | output | LEN_W | Distance to the previous peak (0 for the first) |
| pk_count | output | LEN_W | Number of peaks reported in this scan |
| done | output | 1 | One-cycle end-of-scan pulse |

## Verification
The test windows each separate one rule from the others:
- Evenly spaced tall peaks check the index and the interval bookkeeping.
- A flat-topped pattern separates the strict left comparison from the loose right one.
- Tall samples at both ends of a window check that the boundaries are excluded.
- A window with a maximum of 10 puts one sample exactly on the threshold of 6 and another at 7, which checks the rounding and the strict comparison.
- A small early peak followed by a much larger one shows that the threshold does not depend on the order of samples.
- Lengths of zero, one and two cover the degenerate windows.

// File: rtl/beat_peak_pkg.sv
package beat_peak_pkg;

    typedef enum logic [2:0] {
        S_IDLE,
        S_PASS1,
        S_TAIL1,
        S_THRESH,
        S_PASS2,
        S_TAIL2,
        S_FINISH
    } scan_state_t;

endpackage

// File: rtl/bpk_max_unit.sv
module bpk_max_unit #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         en,
    input  logic [W-1:0] din,
    output logic [W-1:0] max_q
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            max_q <= '0;
        end else if (clr) begin
            max_q <= '0;
        end else if (en && (din > max_q)) begin
            max_q <= din;
        end
    end

    // The running maximum never decreases while samples are taken in
    p_max_monotone_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr && en) |=> (max_q >= $past(max_q)));

endmodule

// File: rtl/bpk_thresh_unit.sv
module bpk_thresh_unit #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] max_in,
    output logic [W-1:0] thr_q
);

    localparam int PW = W + 3;

    logic [PW-1:0] tripled;
    logic [PW-1:0] fifth;

    always_comb begin
        tripled = (PW'(max_in) << 1) + PW'(max_in);
        fifth   = tripled / PW'(5);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            thr_q <= '0;
        end else if (load) begin
            thr_q <= fifth[W-1:0];
        end
    end

    // Threshold stays below the maximum it was derived from
    p_thr_below_max_r2: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (thr_q <= $past(max_in)));

endmodule

// File: rtl/bpk_classify.sv
module bpk_classify #(
    parameter int W  = 16,
    parameter int LW = 12
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          vld,
    input  logic [W-1:0]  smp,
    input  logic [LW-1:0] idx,
    input  logic [W-1:0]  thr,
    output logic          hit,
    output logic [LW-1:0] hit_idx,
    output logic [W-1:0]  hit_amp
);

    logic [W-1:0] left2;
    logic [W-1:0] left1;
    logic [1:0]   fill;

    always_comb begin
        hit     = vld && (fill == 2'd2) && (left1 > thr) &&
                  (left1 > left2) && (left1 >= smp);
        hit_idx = idx - LW'(1);
        hit_amp = left1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            left2 <= '0;
            left1 <= '0;
            fill  <= '0;
        end else if (clr) begin
            fill <= '0;
        end else if (vld) begin
            left2 <= left1;
            left1 <= smp;
            if (fill != 2'd2) begin
                fill <= fill + 2'd1;
            end
        end
    end

    // A candidate always has a sample on each side, so its offset is at least 1
    p_hit_interior_r4: assert property (@(posedge clk) disable iff (!rst_n)
        hit |-> (idx >= LW'(2)));

endmodule

// File: rtl/beat_peak_scan.sv
module beat_peak_scan #(
    parameter int SAMPLE_W = 16,
    parameter int ADDR_W   = 12,
    parameter int LEN_W    = 12
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                start,
    input  logic [ADDR_W-1:0]   win_base,
    input  logic [LEN_W-1:0]    win_len,
    output logic                mem_rd,
    output logic [ADDR_W-1:0]   mem_addr,
    input  logic [SAMPLE_W-1:0] mem_rdata,
    output logic                pk_valid,
    output logic [LEN_W-1:0]    pk_index,
    output logic [SAMPLE_W-1:0] pk_amp,
    output logic [LEN_W-1:0]    pk_gap,
    output logic [LEN_W-1:0]    pk_count,
    output logic                done
);

    import beat_peak_pkg::*;

    scan_state_t state, nxt;

    logic [ADDR_W-1:0]   base_q;
    logic [LEN_W-1:0]    len_q;
    logic [LEN_W-1:0]    rd_cnt;
    logic [LEN_W-1:0]    rv_idx;
    logic                rv;
    logic [LEN_W-1:0]    last_pk;
    logic                accept;
    logic                issuing;
    logic                at_last;
    logic                max_en;
    logic                cls_vld;
    logic [SAMPLE_W-1:0] max_q;
    logic [SAMPLE_W-1:0] thr_q;
    logic                hit;
    logic [LEN_W-1:0]    hit_idx;
    logic [SAMPLE_W-1:0] hit_amp;

    always_comb begin
        accept  = (state == S_IDLE) && start;
        issuing = (state == S_PASS1) || (state == S_PASS2);
        at_last = (rd_cnt == len_q - LEN_W'(1));
        max_en  = rv && ((state == S_PASS1) || (state == S_TAIL1));
        cls_vld = rv && ((state == S_PASS2) || (state == S_TAIL2));
        mem_rd  = issuing;
        mem_addr = base_q + ADDR_W'(rd_cnt);
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= S_IDLE;
        end else begin
            state <= nxt;
        end
    end

    // Transitions
    always_comb begin
        nxt = state;
        unique case (state)
            S_IDLE: begin
                if (start) begin
                    nxt = (win_len == '0) ? S_FINISH : S_PASS1;
                end
            end
            S_PASS1:  if (at_last) nxt = S_TAIL1;
            S_TAIL1:  nxt = S_THRESH;
            S_THRESH: nxt = S_PASS2;
            S_PASS2:  if (at_last) nxt = S_TAIL2;
            S_TAIL2:  nxt = S_FINISH;
            S_FINISH: nxt = S_IDLE;
            default:  nxt = S_IDLE;
        endcase
    end

    // Read sequencing and window capture
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            base_q <= '0;
            len_q  <= '0;
            rd_cnt <= '0;
            rv     <= 1'b0;
            rv_idx <= '0;
        end else begin
            rv     <= issuing;
            rv_idx <= rd_cnt;
            if (accept) begin
                base_q <= win_base;
                len_q  <= win_len;
                rd_cnt <= '0;
            end else if (state == S_THRESH) begin
                rd_cnt <= '0;
            end else if (issuing) begin
                rd_cnt <= rd_cnt + LEN_W'(1);
            end
        end
    end

    bpk_max_unit #(.W(SAMPLE_W)) u_max (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (accept),
        .en    (max_en),
        .din   (mem_rdata),
        .max_q (max_q)
    );

    bpk_thresh_unit #(.W(SAMPLE_W)) u_thr (
        .clk    (clk),
        .rst_n  (rst_n),
        .load   (state == S_THRESH),
        .max_in (max_q),
        .thr_q  (thr_q)
    );

    bpk_classify #(.W(SAMPLE_W), .LW(LEN_W)) u_cls (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (state == S_THRESH),
        .vld     (cls_vld),
        .smp     (mem_rdata),
        .idx     (rv_idx),
        .thr     (thr_q),
        .hit     (hit),
        .hit_idx (hit_idx),
        .hit_amp (hit_amp)
    );

    // Outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pk_valid <= 1'b0;
            pk_index <= '0;
            pk_amp   <= '0;
            pk_gap   <= '0;
            pk_count <= '0;
            last_pk  <= '0;
            done     <= 1'b0;
        end else begin
            done     <= (nxt == S_FINISH);
            pk_valid <= hit;
            if (accept) begin
                pk_count <= '0;
            end else if (hit) begin
                pk_index <= hit_idx;
                pk_amp   <= hit_amp;
                pk_gap   <= (pk_count == '0) ? '0 : (hit_idx - last_pk);
                last_pk  <= hit_idx;
                pk_count <= pk_count + LEN_W'(1);
            end
        end
    end

    p_zero_len_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_IDLE && start && win_len == '0) |=> (done && pk_count == '0));

    p_above_thr_r2: assert property (@(posedge clk) disable iff (!rst_n)
        pk_valid |-> (pk_amp > thr_q));

    p_not_edge_r4: assert property (@(posedge clk) disable iff (!rst_n)
        pk_valid |-> (pk_index != '0 && pk_index < len_q - LEN_W'(1)));

    p_first_gap_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (pk_valid && pk_count == LEN_W'(1)) |-> (pk_gap == '0));

    p_done_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    p_quiet_after_done_r7: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !pk_valid);

    p_peak_le_max_r8: assert property (@(posedge clk) disable iff (!rst_n)
        pk_valid |-> (pk_amp <= max_q));

endmodule

// File: tb/sim_beat_peak_scan.sv
`timescale 1ns/1ps
module sim_beat_peak_scan;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [11:0] win_base = '0;
    logic [11:0] win_len = '0;
    logic        mem_rd;
    logic [11:0] mem_addr;
    logic [15:0] mem_rdata = '0;
    logic        pk_valid;
    logic [11:0] pk_index;
    logic [15:0] pk_amp;
    logic [11:0] pk_gap;
    logic [11:0] pk_count;
    logic        done;

    int total = 0;
    int bad = 0;

    logic [15:0] mem [0:4095];

    int got_n = 0;
    int done_cnt = 0;
    int after_done = 0;
    int got_idx [0:63];
    int got_amp [0:63];
    int got_gap [0:63];

    int exp_n;
    int exp_idx [0:63];
    int exp_amp [0:63];
    int exp_gap [0:63];

    always #4 clk = ~clk;

    beat_peak_scan u0 (
        .clk(clk), .rst_n(rst_n), .start(start),
        .win_base(win_base), .win_len(win_len),
        .mem_rd(mem_rd), .mem_addr(mem_addr), .mem_rdata(mem_rdata),
        .pk_valid(pk_valid), .pk_index(pk_index), .pk_amp(pk_amp),
        .pk_gap(pk_gap), .pk_count(pk_count), .done(done)
    );

    // Synchronous sample memory model
    always @(posedge clk) begin
        if (mem_rd) mem_rdata <= mem[mem_addr];
    end

    // Result collector, sampled away from the active edge
    always @(negedge clk) begin
        if (start) begin
            got_n = 0;
            done_cnt = 0;
            after_done = 0;
        end
        if (pk_valid) begin
            if (done_cnt > 0) after_done = after_done + 1;
            if (got_n < 64) begin
                got_idx[got_n] = int'(pk_index);
                got_amp[got_n] = int'(pk_amp);
                got_gap[got_n] = int'(pk_gap);
            end
            got_n = got_n + 1;
        end
        if (done) done_cnt = done_cnt + 1;
    end

    task automatic check(input string req, input string what, input int act, input int expv);
        total++;
        if (act != expv) begin
            bad++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, expv);
        end
    endtask

    // Reference model built from the requirements
    task automatic model(input int base, input int len);
        int mx;
        int thr;
        int prev;
        mx = 0;
        exp_n = 0;
        prev = -1;
        for (int i = 0; i < len; i++) if (int'(mem[base+i]) > mx) mx = int'(mem[base+i]);
        thr = (mx * 3) / 5;
        for (int i = 1; i < len - 1; i++) begin
            int c;
            c = int'(mem[base+i]);
            if (c > thr && c > int'(mem[base+i-1]) && c >= int'(mem[base+i+1])) begin
                exp_idx[exp_n] = i;
                exp_amp[exp_n] = c;
                exp_gap[exp_n] = (prev < 0) ? 0 : i - prev;
                prev = i;
                exp_n++;
            end
        end
    endtask

    task automatic load(input int base, input int vals[], input int n);
        for (int i = 0; i < n; i++) mem[base+i] = 16'(vals[i]);
    endtask

    task automatic run_window(input string req, input int base, input int len);
        int wait_cyc;
        model(base, len);
        @(negedge clk);
        win_base = 12'(base);
        win_len  = 12'(len);
        start    = 1'b1;
        @(negedge clk);
        start = 1'b0;
        wait_cyc = 0;
        while (done_cnt == 0 && wait_cyc < 400) begin
            @(negedge clk);
            wait_cyc++;
        end
        repeat (3) @(negedge clk);
        check(req, "done pulse count", done_cnt, 1);
        check(req, "peak count", got_n, exp_n);
        check("R7", "pk_count held", int'(pk_count), exp_n);
        check("R7", "peaks after done", after_done, 0);
        for (int k = 0; k < exp_n && k < got_n; k++) begin
            check("R5", "index", got_idx[k], exp_idx[k]);
            check("R5", "amplitude", got_amp[k], exp_amp[k]);
            check("R6", "gap", got_gap[k], exp_gap[k]);
        end
    endtask

    // R9: reset values
    task automatic t_reset();
        check("R9", "done at reset", int'(done), 0);
        check("R9", "pk_valid at reset", int'(pk_valid), 0);
        check("R9", "pk_count at reset", int'(pk_count), 0);
    endtask

    // R5, R6: evenly spaced tall peaks at base 10
    task automatic t_spaced();
        int v[] = '{0, 20, 0, 0, 100, 0, 0, 90, 0, 0, 70, 0};
        load(10, v, 12);
        run_window("R5", 10, 12);
        check("R6", "expected peaks present", got_n, 3);
        check("R6", "third gap", got_gap[2], 3);
    endtask

    // R3: flat tops report only their first sample
    task automatic t_plateau();
        int v[] = '{0, 50, 50, 10, 50, 50, 50, 0};
        load(40, v, 8);
        run_window("R3", 40, 8);
        check("R3", "plateau peak count", got_n, 2);
        check("R3", "second plateau start", got_idx[1], 4);
    endtask

    // R4: window end samples are excluded
    task automatic t_edges();
        int v[] = '{100, 0, 40, 0, 0, 99};
        load(60, v, 6);
        run_window("R4", 60, 6);
        check("R4", "edge peaks suppressed", got_n, 0);
    endtask

    // R2: max 10 gives threshold 6; 6 rejected, 7 accepted
    task automatic t_round();
        int v[] = '{0, 10, 0, 6, 0, 7, 0};
        load(80, v, 7);
        run_window("R2", 80, 7);
        check("R2", "peaks over threshold", got_n, 2);
        check("R2", "seven accepted", got_amp[1], 7);
    endtask

    // R8: early small peak judged against a later maximum
    task automatic t_late_max();
        int v[] = '{0, 50, 0, 0, 0, 0, 100, 0, 0};
        load(100, v, 9);
        run_window("R8", 100, 9);
        check("R8", "only the large peak", got_n, 1);
        check("R8", "large peak offset", got_idx[0], 6);
    endtask

    // R1: zero length finishes at once; short windows give nothing
    task automatic t_short();
        int v[] = '{500, 900};
        load(200, v, 2);
        run_window("R1", 0, 0);
        check("R1", "zero length count", int'(pk_count), 0);
        run_window("R4", 200, 1);
        run_window("R4", 200, 2);
    endtask

    initial begin
        for (int i = 0; i < 4096; i++) mem[i] = '0;
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_spaced();
        t_plateau();
        t_edges();
        t_round();
        t_late_max();
        t_short();
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #1000000;
        total++;
        bad++;
        $display("FAIL watchdog: actual=running expected=finished");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule